// File: doc/BRIEF.md
# Circuit Header Parser

This block reads the first line of an and-inverter-graph circuit description, one byte per valid/ready handshake, and turns it into numbers. The line begins with a three-letter tag. `aag` selects the text variant and `aig` selects the binary variant. After the tag come five unsigned decimal counts, in this fixed order:

- the highest variable index (M)
- the number of inputs (I)
- the number of latches (L)
- the number of outputs (O)
- the number of AND gates (A)

The lexical rules are strict. Each field is preceded by exactly one space. A number may not carry a leading zero unless it is the single digit `0`. A newline must follow the last digit of the AND-gate count at once. When the header is binary, the highest index must equal the sum of inputs, latches and AND gates.

When a header is accepted, the block pulses `done`. It then holds the five counts and the variant flag. When a header is rejected, the block pulses `err` with a 3-bit code. In both cases the block stops taking bytes and stays stopped until a synchronous `restart` pulse. The surrounding reader streams the rest of the file elsewhere. It asserts `inLast` on the final byte of the stream, so that a truncated header can be reported.

Top module: `circuitHeaderParser`

## Requirements
- R1: The first three accepted bytes must be `a`,`a`,`g` (the text variant, which gives `isBinary`=0) or `a`,`i`,`g` (the binary variant, which gives `isBinary`=1). Any other byte in those positions raises `err` with code 1.
- R2: The tag and each count are separated by exactly one space (0x20). A code 2 error is raised in four cases: a byte other than a space after the tag, a non-digit where a count must start, a byte other than a digit, space or newline inside a count, and a newline or space in the wrong place (a newline before the fifth count, or a space after it).
- R3: The counts are delivered in arrival order on `fieldM`, `fieldI`, `fieldL`, `fieldO` and `fieldA`. `done` is high in the cycle after the edge that accepts the newline (0x0A) ending the fifth count.
- R4: A count whose first digit is `0` and is followed by another digit raises code 3. A lone `0` is accepted.
- R5: A count whose value would exceed 4294967295 raises code 4 on the digit that overflows it. The value 4294967295 itself is accepted.
- R6: In the binary variant, M must equal I+L+A, computed without wrap-around, or code 5 is raised instead of `done`. The text variant performs no such check.
- R7: A byte accepted with `inLast`=1 that neither ends the header nor is itself a lexical error raises code 6. A lexical error on that same byte reports its own code. A final newline carrying `inLast` gives `done`.
- R8: After `done` or `err`, `inReady` is 0, no byte is taken, and the counts and flag hold. A `restart` pulse returns `inReady` to 1 and clears the counts, `isBinary` and `errCode` to 0.
- R9: `done` and `err` are single-cycle pulses and never occur together. `errCode` is nonzero with `err` and holds until restart.
- R10: After reset, `inReady`=1, `done`=0, `err`=0, `errCode`=0 and all counts are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| restart | input | 1 | Synchronous pulse that rearms the parser |
| inValid | input | 1 | Byte on `inByte` is offered |
| inByte | input | 8 | Stream byte |
| inLast | input | 1 | Offered byte is the last of the stream |
| inReady | output | 1 | Parser takes a byte this cycle |
| isBinary | output | 1 | 1 when the tag named the binary variant |
| fieldM | output | 32 | Highest variable index |
| fieldI | output | 32 | Input count |
| fieldL | output | 32 | Latch count |
| fieldO | output | 32 | Output count |
| fieldA | output | 32 | AND-gate count |
| done | output | 1 | Header accepted (one-cycle pulse) |
| err | output | 1 | Header rejected (one-cycle pulse) |
| errCode | output | 3 | Reason for rejection |

## Verification
Every verdict is decided by the byte that a rising edge accepts. `done` or `err`, together with `errCode`, becomes visible right after that same edge, and `inReady` falls at the same moment. The bench drives each byte at a falling edge and samples the pulses at the next falling edge, which is exactly one accepting edge later. It then samples once more a cycle later to confirm that the pulse has cleared. Counts and the variant flag are read after the verdict, while the block is halted, and again after a restart edge.

// File: rtl/hdr_pkg.sv
package hdr_pkg;

  typedef enum logic [2:0] {
    ERR_NONE      = 3'd0,
    ERR_IDENT     = 3'd1,
    ERR_SEPARATOR = 3'd2,
    ERR_LEAD_ZERO = 3'd3,
    ERR_OVERFLOW  = 3'd4,
    ERR_SUM       = 3'd5,
    ERR_EARLY_END = 3'd6
  } errCode_e;

  // field positions; the sum rule depends on them
  localparam int IDX_M = 0;
  localparam int IDX_I = 1;
  localparam int IDX_L = 2;
  localparam int IDX_O = 3;
  localparam int IDX_A = 4;

  typedef struct packed {
    logic clearAll;
    logic pushDigit;
    logic setBinary;
  } dpStrobe_t;

endpackage

// File: rtl/hdrDatapath.sv
module hdrDatapath
  import hdr_pkg::*;
#(
  parameter int FIELD_W    = 32,
  parameter int NUM_FIELDS = 5,
  parameter int IDX_W      = 3
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  dpStrobe_t                     strobe,
  input  logic [IDX_W-1:0]              selIdx,
  input  logic [3:0]                    digitIn,
  output logic [NUM_FIELDS*FIELD_W-1:0] fieldsFlat,
  output logic                          isBinary,
  output logic                          wouldOverflow,
  output logic                          sumMatches
);

  localparam int EXT_W = FIELD_W + 4;
  localparam int SUM_W = FIELD_W + 2;

  logic [FIELD_W-1:0] fieldReg [NUM_FIELDS];
  logic [EXT_W-1:0]   scaled;
  logic [SUM_W-1:0]   partSum;

  always_comb begin
    scaled        = EXT_W'(fieldReg[selIdx]) * EXT_W'(10) + EXT_W'(digitIn);
    wouldOverflow = |scaled[EXT_W-1:FIELD_W];
    partSum       = SUM_W'(fieldReg[IDX_I]) + SUM_W'(fieldReg[IDX_L]) + SUM_W'(fieldReg[IDX_A]);
    sumMatches    = (SUM_W'(fieldReg[IDX_M]) == partSum);
  end

  for (genvar k = 0; k < NUM_FIELDS; k++) begin : g_field
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        fieldReg[k] <= '0;
      else if (strobe.clearAll)
        fieldReg[k] <= '0;
      else if (strobe.pushDigit && selIdx == IDX_W'(k))
        fieldReg[k] <= scaled[FIELD_W-1:0];
    end
    assign fieldsFlat[k*FIELD_W +: FIELD_W] = fieldReg[k];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 isBinary <= 1'b0;
    else if (strobe.clearAll)  isBinary <= 1'b0;
    else if (strobe.setBinary) isBinary <= 1'b1;
  end

  // R5: control never commits a digit that would overflow its field
  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.pushDigit |-> !wouldOverflow);

  // R8: counts hold whenever no digit is committed and no clear is requested
  p_fields_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.pushDigit && !strobe.clearAll) |=> $stable(fieldsFlat));

endmodule

// File: rtl/hdrControl.sv
module hdrControl
  import hdr_pkg::*;
#(
  parameter int NUM_FIELDS = 5,
  parameter int IDX_W      = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             restart,
  input  logic             inValid,
  input  logic [7:0]       inByte,
  input  logic             inLast,
  input  logic             wouldOverflow,
  input  logic             sumMatches,
  input  logic             isBinary,
  output logic             inReady,
  output dpStrobe_t        strobe,
  output logic [IDX_W-1:0] selIdx,
  output logic             done,
  output logic             err,
  output errCode_e         errCode
);

  typedef enum logic [2:0] {
    S_ID0, S_ID1, S_ID2, S_ID_SP, S_NUM_FIRST, S_NUM_MORE, S_HALT
  } state_e;

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_FIELDS - 1);

  state_e           state, nextState;
  logic [IDX_W-1:0] nextIdx;
  logic             leadZero, nextLead;
  logic             accept, isDigit, finish, pushReq, binReq, finishOk;
  errCode_e         lexCode, raiseCode;

  assign inReady = (state != S_HALT);
  assign accept  = inValid && inReady;
  assign isDigit = (inByte >= 8'h30) && (inByte <= 8'h39);

  always_comb begin
    nextState = state;
    nextIdx   = selIdx;
    nextLead  = leadZero;
    lexCode   = ERR_NONE;
    finish    = 1'b0;
    pushReq   = 1'b0;
    binReq    = 1'b0;
    case (state)
      S_ID0: begin
        if (inByte != "a") lexCode = ERR_IDENT;
        nextState = S_ID1;
      end
      S_ID1: begin
        if (inByte == "i") binReq = 1'b1;
        else if (inByte != "a") lexCode = ERR_IDENT;
        nextState = S_ID2;
      end
      S_ID2: begin
        if (inByte != "g") lexCode = ERR_IDENT;
        nextState = S_ID_SP;
      end
      S_ID_SP: begin
        if (inByte != 8'h20) lexCode = ERR_SEPARATOR;
        nextState = S_NUM_FIRST;
        nextIdx   = '0;
      end
      S_NUM_FIRST: begin
        if (!isDigit) lexCode = ERR_SEPARATOR;
        else if (wouldOverflow) lexCode = ERR_OVERFLOW;
        else pushReq = 1'b1;
        nextLead  = (inByte == 8'h30);
        nextState = S_NUM_MORE;
      end
      S_NUM_MORE: begin
        if (isDigit) begin
          if (leadZero) lexCode = ERR_LEAD_ZERO;
          else if (wouldOverflow) lexCode = ERR_OVERFLOW;
          else pushReq = 1'b1;
        end else if (inByte == 8'h20) begin
          if (selIdx == LAST_IDX) lexCode = ERR_SEPARATOR;
          nextIdx   = selIdx + IDX_W'(1);
          nextState = S_NUM_FIRST;
        end else if (inByte == 8'h0A) begin
          if (selIdx == LAST_IDX) finish = 1'b1;
          else lexCode = ERR_SEPARATOR;
        end else begin
          lexCode = ERR_SEPARATOR;
        end
      end
      default: ;
    endcase

    raiseCode = lexCode;
    if (lexCode == ERR_NONE) begin
      if (finish) begin
        if (isBinary && !sumMatches) raiseCode = ERR_SUM;
      end else if (inLast) begin
        raiseCode = ERR_EARLY_END;
      end
    end
    finishOk = finish && (raiseCode == ERR_NONE);

    strobe.clearAll  = restart;
    strobe.pushDigit = accept && !restart && pushReq && (raiseCode == ERR_NONE);
    strobe.setBinary = accept && !restart && binReq;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_ID0; selIdx <= '0; leadZero <= 1'b0;
      done <= 1'b0; err <= 1'b0; errCode <= ERR_NONE;
    end else if (restart) begin
      state <= S_ID0; selIdx <= '0; leadZero <= 1'b0;
      done <= 1'b0; err <= 1'b0; errCode <= ERR_NONE;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      if (accept) begin
        if (raiseCode != ERR_NONE) begin
          err     <= 1'b1;
          errCode <= raiseCode;
          state   <= S_HALT;
        end else if (finishOk) begin
          done  <= 1'b1;
          state <= S_HALT;
        end else begin
          state    <= nextState;
          selIdx   <= nextIdx;
          leadZero <= nextLead;
        end
      end
    end
  end

  // R9: a verdict is either acceptance or rejection, never both
  p_one_verdict_r9: assert property (@(posedge clk) disable iff (!rstN)
    !(done && err));

  // R9: done lasts a single cycle
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R9: a rejection always carries a reason
  p_err_code_r9: assert property (@(posedge clk) disable iff (!rstN)
    err |-> (errCode != ERR_NONE));

  // R8: after a verdict the stream is not taken
  p_halt_r8: assert property (@(posedge clk) disable iff (!rstN)
    (done || err) |-> !inReady);

endmodule

// File: rtl/circuitHeaderParser.sv
module circuitHeaderParser
  import hdr_pkg::*;
#(
  parameter int FIELD_W = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               restart,
  input  logic               inValid,
  input  logic [7:0]         inByte,
  input  logic               inLast,
  output logic               inReady,
  output logic               isBinary,
  output logic [FIELD_W-1:0] fieldM,
  output logic [FIELD_W-1:0] fieldI,
  output logic [FIELD_W-1:0] fieldL,
  output logic [FIELD_W-1:0] fieldO,
  output logic [FIELD_W-1:0] fieldA,
  output logic               done,
  output logic               err,
  output logic [2:0]         errCode
);

  localparam int NUM_FIELDS = 5;
  localparam int IDX_W      = $clog2(NUM_FIELDS);

  dpStrobe_t                     strobe;
  logic [IDX_W-1:0]              selIdx;
  logic [NUM_FIELDS*FIELD_W-1:0] fieldsFlat;
  logic                          wouldOverflow, sumMatches;
  errCode_e                      codeEnum;

  hdrControl #(.NUM_FIELDS(NUM_FIELDS), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .restart(restart),
    .inValid(inValid), .inByte(inByte), .inLast(inLast),
    .wouldOverflow(wouldOverflow), .sumMatches(sumMatches), .isBinary(isBinary),
    .inReady(inReady), .strobe(strobe), .selIdx(selIdx),
    .done(done), .err(err), .errCode(codeEnum)
  );

  hdrDatapath #(.FIELD_W(FIELD_W), .NUM_FIELDS(NUM_FIELDS), .IDX_W(IDX_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .selIdx(selIdx),
    .digitIn(inByte[3:0]), .fieldsFlat(fieldsFlat), .isBinary(isBinary),
    .wouldOverflow(wouldOverflow), .sumMatches(sumMatches)
  );

  assign errCode = codeEnum;
  assign fieldM  = fieldsFlat[IDX_M*FIELD_W +: FIELD_W];
  assign fieldI  = fieldsFlat[IDX_I*FIELD_W +: FIELD_W];
  assign fieldL  = fieldsFlat[IDX_L*FIELD_W +: FIELD_W];
  assign fieldO  = fieldsFlat[IDX_O*FIELD_W +: FIELD_W];
  assign fieldA  = fieldsFlat[IDX_A*FIELD_W +: FIELD_W];

  // R6: an accepted binary header obeys the index sum rule at the ports
  p_bin_sum_r6: assert property (@(posedge clk) disable iff (!rstN)
    (done && isBinary) |->
      ({2'b00, fieldM} == {2'b00, fieldI} + {2'b00, fieldL} + {2'b00, fieldA}));

  // R8: a restart rearms the parser cleanly
  p_rearm_r8: assert property (@(posedge clk) disable iff (!rstN)
    restart |=> (inReady && !done && !err && errCode == 3'd0));

endmodule

// File: tb/circuitHeaderParser_test.sv
module circuitHeaderParser_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        restart = 1'b0;
  logic        inValid = 1'b0;
  logic [7:0]  inByte = 8'h00;
  logic        inLast = 1'b0;
  logic        inReady, isBinary, done, err;
  logic [31:0] fieldM, fieldI, fieldL, fieldO, fieldA;
  logic [2:0]  errCode;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  bit       gotDone, gotErr;
  logic [2:0] gotCode;

  always #4 clk = ~clk;

  circuitHeaderParser uut (
    .clk(clk), .rstN(rstN), .restart(restart), .inValid(inValid),
    .inByte(inByte), .inLast(inLast), .inReady(inReady), .isBinary(isBinary),
    .fieldM(fieldM), .fieldI(fieldI), .fieldL(fieldL), .fieldO(fieldO),
    .fieldA(fieldA), .done(done), .err(err), .errCode(errCode)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic checkEq(input string req, input string what,
                         input longint act, input longint exp);
    check(act == exp, req, what, act, exp);
  endtask

  task automatic doRestart();
    @(negedge clk) restart = 1'b1;
    @(negedge clk) restart = 1'b0;
  endtask

  // sends bytes until a verdict or the text runs out; lastAt marks the inLast byte
  task automatic runCase(input string txt, input int lastAt);
    doRestart();
    gotDone = 1'b0; gotErr = 1'b0; gotCode = 3'd0;
    for (int i = 0; i < txt.len(); i++) begin
      if (!inReady) break;
      inValid = 1'b1;
      inByte  = txt[i];
      inLast  = (i == lastAt);
      @(negedge clk);
      inValid = 1'b0;
      inLast  = 1'b0;
      if (done) gotDone = 1'b1;
      if (err) begin gotErr = 1'b1; gotCode = errCode; end
    end
    @(negedge clk);
    checkEq("R9", "pulse cleared next cycle", longint'(done || err), 0);
  endtask

  task automatic expectErr(input string req, input string txt, input int lastAt,
                           input int code);
    runCase(txt, lastAt);
    checkEq(req, {"err pulse for '", txt, "'"}, longint'(gotErr), 1);
    checkEq(req, "error code", longint'(gotCode), code);
    checkEq(req, "no done on error", longint'(gotDone), 0);
  endtask

  task automatic testReset();
    checkEq("R10", "inReady after reset", longint'(inReady), 1);
    checkEq("R10", "done after reset", longint'(done), 0);
    checkEq("R10", "err after reset", longint'(err), 0);
    checkEq("R10", "errCode after reset", longint'(errCode), 0);
    checkEq("R10", "fieldM after reset", longint'(fieldM), 0);
    checkEq("R10", "fieldA after reset", longint'(fieldA), 0);
  endtask

  task automatic testAscii();
    runCase("aag 7 2 0 2 3\n", -1);
    checkEq("R3", "done for text header", longint'(gotDone), 1);
    checkEq("R1", "text variant flag", longint'(isBinary), 0);
    checkEq("R3", "fieldM", longint'(fieldM), 7);
    checkEq("R3", "fieldI", longint'(fieldI), 2);
    checkEq("R3", "fieldL", longint'(fieldL), 0);
    checkEq("R3", "fieldO", longint'(fieldO), 2);
    checkEq("R3", "fieldA", longint'(fieldA), 3);
    runCase("aag 1234 56 789 10 20\n", -1);
    checkEq("R3", "done multi-digit", longint'(gotDone), 1);
    checkEq("R3", "fieldM multi-digit", longint'(fieldM), 1234);
    checkEq("R3", "fieldL multi-digit", longint'(fieldL), 789);
    checkEq("R3", "fieldA multi-digit", longint'(fieldA), 20);
  endtask

  task automatic testBinary();
    runCase("aig 5 2 1 1 2\n", -1);
    checkEq("R1", "done for binary header", longint'(gotDone), 1);
    checkEq("R1", "binary variant flag", longint'(isBinary), 1);
    checkEq("R6", "binary fieldM", longint'(fieldM), 5);
    expectErr("R6", "aig 5 1 1 1 1\n", -1, 5);
    expectErr("R6", "aig 0 4294967295 1 0 0\n", -1, 5);
    runCase("aag 9 1 1 1 1\n", -1);
    checkEq("R6", "text variant skips sum rule", longint'(gotDone), 1);
  endtask

  task automatic testIdent();
    expectErr("R1", "abg 1 1 0 0 0\n", -1, 1);
    expectErr("R1", "aax 1 1 0 0 0\n", -1, 1);
    expectErr("R1", "bag 1 1 0 0 0\n", -1, 1);
  endtask

  task automatic testSeparator();
    expectErr("R2", "aag  1 1 0 0 0\n", -1, 2);
    expectErr("R2", "aag1 1 0 0 0\n", -1, 2);
    expectErr("R2", "aag 1 2 3 4\n", -1, 2);
    expectErr("R2", "aag 1 2 3 4 5 6\n", -1, 2);
    expectErr("R2", "aag 1 2 x 4 5\n", -1, 2);
    expectErr("R2", "aag 1 2 3 4 5 \n", -1, 2);
  endtask

  task automatic testLeadZero();
    expectErr("R4", "aag 01 1 0 0 0\n", -1, 3);
    expectErr("R4", "aag 1 1 0 00 0\n", -1, 3);
    runCase("aag 0 0 0 0 0\n", -1);
    checkEq("R4", "all single zeros accepted", longint'(gotDone), 1);
    runCase("aag 10 0 0 0 0\n", -1);
    checkEq("R4", "zero after nonzero accepted", longint'(fieldM), 10);
  endtask

  task automatic testOverflow();
    expectErr("R5", "aag 4294967296 0 0 0 0\n", -1, 4);
    expectErr("R5", "aag 0 0 0 0 99999999999\n", -1, 4);
    runCase("aag 4294967295 0 0 0 0\n", -1);
    checkEq("R5", "max value accepted", longint'(gotDone), 1);
    checkEq("R5", "max value fieldM", longint'(fieldM), 64'd4294967295);
  endtask

  task automatic testEarlyEnd();
    expectErr("R7", "aag 1 2", 6, 6);
    expectErr("R7", "aa", 1, 6);
    expectErr("R7", "aag x", 4, 2);
    runCase("aag 1 1 0 0 0\n", 13);
    checkEq("R7", "last on final newline gives done", longint'(gotDone), 1);
    checkEq("R7", "no err with final last", longint'(gotErr), 0);
  endtask

  task automatic testHoldRestart();
    runCase("aig 3 1 1 1 1\n", -1);
    checkEq("R8", "setup done", longint'(gotDone), 1);
    for (int k = 0; k < 3; k++) begin
      inValid = 1'b1; inByte = "9"; inLast = 1'b1;
      @(negedge clk);
      checkEq("R8", "inReady low while halted", longint'(inReady), 0);
      checkEq("R8", "no pulse while halted", longint'(done || err), 0);
    end
    inValid = 1'b0; inLast = 1'b0;
    checkEq("R8", "fieldM held", longint'(fieldM), 3);
    checkEq("R8", "fieldA held", longint'(fieldA), 1);
    checkEq("R8", "flag held", longint'(isBinary), 1);
    doRestart();
    checkEq("R8", "inReady after restart", longint'(inReady), 1);
    checkEq("R8", "fieldM cleared", longint'(fieldM), 0);
    checkEq("R8", "fieldI cleared", longint'(fieldI), 0);
    checkEq("R8", "flag cleared", longint'(isBinary), 0);
    expectErr("R9", "aig 2 1 1 1 1\n", -1, 5);
    checkEq("R9", "errCode held after err", longint'(errCode), 5);
    doRestart();
    checkEq("R8", "errCode cleared by restart", longint'(errCode), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testAscii();
    testBinary();
    testIdent();
    testSeparator();
    testLeadZero();
    testOverflow();
    testEarlyEnd();
    testHoldRestart();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule